// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the integer execution stage of a 32-bit RISC pipeline, built as pure combinational logic. The upstream stage presents the raw opcode and function-code fields of the instruction, the shift-amount field, both register indices from the instruction word, the two operand values read from the register file and the 16-bit immediate. In the same cycle the block returns the computed value and the index of the register to write. It also returns a write enable, a signed-overflow trap request and a flag for encodings it does not recognise.

The decode covers register-register and register-immediate addition and subtraction, the four bitwise operations, signed set-less-than, shifts by a constant held in the instruction, and loading a constant into the upper half of a word. The opcode decides whether the immediate is sign-extended or padded with zeros. Only the signed add and subtract forms can raise a trap, and a trapping instruction leaves its destination unwritten. Writes aimed at register 0 are dropped, because that register always reads as zero. The register file, the trap handler and the pipeline registers around the block sit outside it. The block has no valid/ready interface because it holds no state and cannot stall: the surrounding pipeline registers provide the flow control.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0x00, function 0x20 outputs the 32-bit wrapping sum rs+rt and raises the trap when the signed sum overflows. Function 0x21 outputs the same sum and never raises the trap.
- R2: With opcode 0x00, function 0x22 outputs the wrapping difference rs-rt and raises the trap on signed overflow. Function 0x23 outputs the same difference and never raises the trap.
- R3: Opcodes 0x08 and 0x09 add rs to the sign-extended immediate. Opcode 0x08 raises the trap on signed overflow and 0x09 never does.
- R4: Opcodes 0x0C and 0x0D output rs AND or OR the immediate with its upper 16 bits zero. With opcode 0x00, functions 0x24, 0x25, 0x26 and 0x27 output rs AND, OR, XOR and NOR rt.
- R5: Function 0x2A (opcode 0x00) and opcode 0x0A output 1 when rs is less than rt or the sign-extended immediate, compared as signed two's-complement values, and 0 otherwise.
- R6: With opcode 0x00, functions 0x00, 0x02 and 0x03 shift rt by the shift-amount field: left with zero fill, right with zero fill, and right copying the sign bit.
- R7: Opcode 0x0F outputs the immediate in bits 31:16 with bits 15:0 zero, whatever the value of rs.
- R8: The write index is the rt field for opcodes 0x08, 0x09, 0x0A, 0x0C, 0x0D and 0x0F and the rd field for every other opcode. The write enable is 0 whenever that index is 0.
- R9: Whenever the trap request is 1, the write enable is 0.
- R10: Any opcode/function pair not listed in R1–R7 raises the reserved-encoding flag and drives the write enable 0, the trap 0 and the result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Primary opcode field |
| fn_i | input | 6 | Function field (used when opcode is 0x00) |
| sa_i | input | 5 | Shift-amount field |
| rd_idx_i | input | 5 | rd register index from the instruction |
| rt_idx_i | input | 5 | rt register index from the instruction |
| rs_val_i | input | 32 | First operand value |
| rt_val_i | input | 32 | Second operand value |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Computed value |
| wr_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Destination write enable |
| ovf_trap_o | output | 1 | Signed-overflow trap request |
| illegal_o | output | 1 | Reserved-encoding flag |

## Verification
The bench targets the overflow boundaries: the largest positive value plus one and the most negative value minus one. A design that ignored the per-opcode trap enable would raise traps on the unsigned forms, and one that kept the write enabled would corrupt the destination. It also compares immediates with bit 15 set across the sign-extending and zero-padding opcodes, where a shared extension would give wrong AND/OR and add results. It checks signed comparisons across zero, where an unsigned compare inverts the answer, and arithmetic right shifts of a negative value, which expose a zero fill. Register-0 destinations on both R-type and I-type forms, together with several reserved encodings, confirm that no write escapes and that nothing non-zero is driven.

// File: rtl/iex_pkg.sv
package iex_pkg;

  localparam int OPC_W = 6;

  // primary opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDT  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDW  = 6'h09;
  localparam logic [OPC_W-1:0] OPC_LTI   = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_UPPER = 6'h0F;

  // function codes under OPC_REG
  localparam logic [OPC_W-1:0] FN_SHL  = 6'h00;
  localparam logic [OPC_W-1:0] FN_SHRL = 6'h02;
  localparam logic [OPC_W-1:0] FN_SHRA = 6'h03;
  localparam logic [OPC_W-1:0] FN_ADDT = 6'h20;
  localparam logic [OPC_W-1:0] FN_ADDW = 6'h21;
  localparam logic [OPC_W-1:0] FN_SUBT = 6'h22;
  localparam logic [OPC_W-1:0] FN_SUBW = 6'h23;
  localparam logic [OPC_W-1:0] FN_AND  = 6'h24;
  localparam logic [OPC_W-1:0] FN_OR   = 6'h25;
  localparam logic [OPC_W-1:0] FN_XOR  = 6'h26;
  localparam logic [OPC_W-1:0] FN_NOR  = 6'h27;
  localparam logic [OPC_W-1:0] FN_LT   = 6'h2A;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
    K_SLT, K_SHL, K_SHRL, K_SHRA, K_UPPER
  } kind_e;

  typedef struct packed {
    logic  legal;
    kind_e kind;
    logic  use_imm;
    logic  imm_signed;
    logic  trap_en;
    logic  dst_is_rt;
  } ctl_t;

endpackage

// File: rtl/iex_decode.sv
module iex_decode
  import iex_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  input  logic [OPC_W-1:0] fn_i,
  output ctl_t             ctl_o
);

  ctl_t reg_ctl;
  ctl_t imm_ctl;

  // register-register forms
  always_comb begin
    reg_ctl            = '0;
    reg_ctl.kind       = K_ADD;
    reg_ctl.legal      = 1'b1;
    unique case (fn_i)
      FN_ADDT: begin reg_ctl.kind = K_ADD;  reg_ctl.trap_en = 1'b1; end
      FN_ADDW:       reg_ctl.kind = K_ADD;
      FN_SUBT: begin reg_ctl.kind = K_SUB;  reg_ctl.trap_en = 1'b1; end
      FN_SUBW:       reg_ctl.kind = K_SUB;
      FN_AND:        reg_ctl.kind = K_AND;
      FN_OR:         reg_ctl.kind = K_OR;
      FN_XOR:        reg_ctl.kind = K_XOR;
      FN_NOR:        reg_ctl.kind = K_NOR;
      FN_LT:         reg_ctl.kind = K_SLT;
      FN_SHL:        reg_ctl.kind = K_SHL;
      FN_SHRL:       reg_ctl.kind = K_SHRL;
      FN_SHRA:       reg_ctl.kind = K_SHRA;
      default:       reg_ctl.legal = 1'b0;
    endcase
  end

  // immediate forms
  always_comb begin
    imm_ctl           = '0;
    imm_ctl.kind      = K_ADD;
    imm_ctl.legal     = 1'b1;
    imm_ctl.use_imm   = 1'b1;
    imm_ctl.dst_is_rt = 1'b1;
    unique case (op_i)
      OPC_ADDT: begin
        imm_ctl.kind       = K_ADD;
        imm_ctl.imm_signed = 1'b1;
        imm_ctl.trap_en    = 1'b1;
      end
      OPC_ADDW: begin
        imm_ctl.kind       = K_ADD;
        imm_ctl.imm_signed = 1'b1;
      end
      OPC_LTI: begin
        imm_ctl.kind       = K_SLT;
        imm_ctl.imm_signed = 1'b1;
      end
      OPC_ANDI:  imm_ctl.kind = K_AND;
      OPC_ORI:   imm_ctl.kind = K_OR;
      OPC_UPPER: imm_ctl.kind = K_UPPER;
      default: begin
        imm_ctl.legal     = 1'b0;
        imm_ctl.dst_is_rt = 1'b0;
      end
    endcase
  end

  assign ctl_o = (op_i == OPC_REG) ? reg_ctl : imm_ctl;

endmodule

// File: rtl/iex_operand.sv
module iex_operand #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  input  logic              imm_signed_i,
  output logic [DATA_W-1:0] opb_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic              fill;
  logic [DATA_W-1:0] imm_ext;

  assign fill    = imm_signed_i & imm_i[IMM_W-1];
  assign imm_ext = {{PAD_W{fill}}, imm_i};
  assign opb_o   = use_imm_i ? imm_ext : rt_val_i;

endmodule

// File: rtl/iex_addsub.sv
module iex_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              lt_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;

  // one adder serves add, subtract and compare
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};

  // operands agree in sign (after inversion), result disagrees
  assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

  // signed less-than: sign of difference corrected by overflow
  assign lt_o  = sum_o[MSB] ^ ovf_o;

endmodule

// File: rtl/iex_shifter.sv
module iex_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] res_o
);

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic              fill;
  logic [DATA_W-1:0] stage [0:SH_W];

  // left shifts run through the right shifter on a mirrored word
  assign fill     = arith_i & ~left_i & val_i[DATA_W-1];
  assign stage[0] = left_i ? flip(val_i) : val_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]}
                                 : stage[s];
  end

  assign res_o = left_i ? flip(stage[SH_W]) : stage[SH_W];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iex_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [OPC_W-1:0]  op_i,
  input  logic [OPC_W-1:0]  fn_i,
  input  logic [SH_W-1:0]   sa_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              wr_en_o,
  output logic              ovf_trap_o,
  output logic              illegal_o
);

  localparam int LOW_W = DATA_W - IMM_W;

  ctl_t              ctl;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] sum;
  logic              ovf;
  logic              lt;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] value;
  logic              is_sub;
  logic              trap_hit;

  iex_decode u_dec (
    .op_i  (op_i),
    .fn_i  (fn_i),
    .ctl_o (ctl)
  );

  iex_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .rt_val_i     (rt_val_i),
    .imm_i        (imm_i),
    .use_imm_i    (ctl.use_imm),
    .imm_signed_i (ctl.imm_signed),
    .opb_o        (opb)
  );

  assign is_sub = (ctl.kind == K_SUB) || (ctl.kind == K_SLT);

  iex_addsub #(.DATA_W(DATA_W)) u_add (
    .a_i   (rs_val_i),
    .b_i   (opb),
    .sub_i (is_sub),
    .sum_o (sum),
    .ovf_o (ovf),
    .lt_o  (lt)
  );

  iex_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shf (
    .val_i   (opb),
    .amt_i   (sa_i),
    .left_i  (ctl.kind == K_SHL),
    .arith_i (ctl.kind == K_SHRA),
    .res_o   (shifted)
  );

  always_comb begin
    unique case (ctl.kind)
      K_ADD, K_SUB:         value = sum;
      K_AND:                value = rs_val_i & opb;
      K_OR:                 value = rs_val_i | opb;
      K_XOR:                value = rs_val_i ^ opb;
      K_NOR:                value = ~(rs_val_i | opb);
      K_SLT:                value = {{(DATA_W-1){1'b0}}, lt};
      K_SHL, K_SHRL, K_SHRA: value = shifted;
      K_UPPER:              value = {imm_i, {LOW_W{1'b0}}};
      default:              value = '0;
    endcase
  end

  assign trap_hit   = ctl.legal && ctl.trap_en && ovf;
  assign result_o   = ctl.legal ? value : '0;
  assign wr_idx_o   = ctl.dst_is_rt ? rt_idx_i : rd_idx_i;
  assign ovf_trap_o = trap_hit;
  assign illegal_o  = ~ctl.legal;
  assign wr_en_o    = ctl.legal && !trap_hit && (wr_idx_o != '0);

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic [5:0]        op_i,
  input logic [5:0]        fn_i,
  input logic [DATA_W-1:0] result_o,
  input logic [IDX_W-1:0]  wr_idx_o,
  input logic              wr_en_o,
  input logic              ovf_trap_o,
  input logic              illegal_o
);

  logic unsigned_arith;
  logic compare_op;
  logic logic_imm;

  assign unsigned_arith = (op_i == 6'h00 && (fn_i == 6'h21 || fn_i == 6'h23)) ||
                          (op_i == 6'h09);
  assign compare_op     = (op_i == 6'h00 && fn_i == 6'h2A) || (op_i == 6'h0A);
  assign logic_imm      = (op_i == 6'h0C) || (op_i == 6'h0D) || (op_i == 6'h0F);

  always_comb begin
    // R9
    a_r9_trap_blocks_write: assert (!(ovf_trap_o && wr_en_o))
      else $error("trap raised while write enabled");
    // R8
    a_r8_no_zero_write: assert (!(wr_en_o && wr_idx_o == '0))
      else $error("write enabled toward register 0");
    // R10
    a_r10_illegal_quiet: assert (!illegal_o || (!wr_en_o && !ovf_trap_o && result_o == '0))
      else $error("reserved encoding produced activity");
    // R1, R2, R3 unsigned forms
    a_r1_unsigned_no_trap: assert (!(unsigned_arith && ovf_trap_o))
      else $error("non-trapping arithmetic raised trap");
    // R5
    a_r5_compare_boolean: assert (!compare_op || result_o[DATA_W-1:1] == '0)
      else $error("compare result not 0/1");
    // R4, R7
    a_r4_logic_no_trap: assert (!(logic_imm && ovf_trap_o))
      else $error("logical immediate raised trap");
  end

endmodule

bind int_exec_unit int_exec_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) chk_i (
  .op_i       (op_i),
  .fn_i       (fn_i),
  .result_o   (result_o),
  .wr_idx_o   (wr_idx_o),
  .wr_en_o    (wr_en_o),
  .ovf_trap_o (ovf_trap_o),
  .illegal_o  (illegal_o)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op, fn;
  logic [4:0]  sa, rd_idx, rt_idx;
  logic [31:0] rs_val, rt_val;
  logic [15:0] imm;
  logic [31:0] result;
  logic [4:0]  wr_idx;
  logic        wr_en, trap, ill;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  int_exec_unit dut_i (
    .op_i(op), .fn_i(fn), .sa_i(sa), .rd_idx_i(rd_idx), .rt_idx_i(rt_idx),
    .rs_val_i(rs_val), .rt_val_i(rt_val), .imm_i(imm),
    .result_o(result), .wr_idx_o(wr_idx), .wr_en_o(wr_en),
    .ovf_trap_o(trap), .illegal_o(ill)
  );

  task automatic apply(input logic [5:0] o, input logic [5:0] f, input logic [4:0] s,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] i,
                       input logic [4:0] rd, input logic [4:0] rt);
    @(posedge clk);
    op = o; fn = f; sa = s; rs_val = a; rt_val = b; imm = i; rd_idx = rd; rt_idx = rt;
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [31:0] er, input logic et,
                            input logic ew, input logic [4:0] ei, input logic eil);
    n_chk++;
    if (result !== er || trap !== et || wr_en !== ew || wr_idx !== ei || ill !== eil) begin
      n_err++;
      $display("FAIL %s: got res=%h trap=%b we=%b idx=%0d ill=%b expected res=%h trap=%b we=%b idx=%0d ill=%b",
               tag, result, trap, wr_en, wr_idx, ill, er, et, ew, ei, eil);
    end
  endtask

  task automatic t_reset_state();
    apply(6'h00, 6'h00, 5'd0, 32'h0, 32'h0, 16'h0, 5'd0, 5'd0);
    expect_out("R8 idle sll to r0", 32'h0, 1'b0, 1'b0, 5'd0, 1'b0);
  endtask

  task automatic t_add();
    apply(6'h00, 6'h20, 5'd0, 32'd5, 32'd7, 16'h0, 5'd3, 5'd9);
    expect_out("R1 add plain", 32'd12, 1'b0, 1'b1, 5'd3, 1'b0);
    apply(6'h00, 6'h20, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd3, 5'd9);
    expect_out("R1 R9 add overflow", 32'h8000_0000, 1'b1, 1'b0, 5'd3, 1'b0);
    apply(6'h00, 6'h21, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd3, 5'd9);
    expect_out("R1 addu no trap", 32'h8000_0000, 1'b0, 1'b1, 5'd3, 1'b0);
    apply(6'h00, 6'h20, 5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd4, 5'd9);
    expect_out("R1 add -1+1 no overflow", 32'h0, 1'b0, 1'b1, 5'd4, 1'b0);
  endtask

  task automatic t_sub();
    apply(6'h00, 6'h22, 5'd0, 32'd10, 32'd3, 16'h0, 5'd5, 5'd1);
    expect_out("R2 sub plain", 32'd7, 1'b0, 1'b1, 5'd5, 1'b0);
    apply(6'h00, 6'h22, 5'd0, 32'h8000_0000, 32'd1, 16'h0, 5'd5, 5'd1);
    expect_out("R2 R9 sub overflow", 32'h7FFF_FFFF, 1'b1, 1'b0, 5'd5, 1'b0);
    apply(6'h00, 6'h23, 5'd0, 32'h8000_0000, 32'd1, 16'h0, 5'd5, 5'd1);
    expect_out("R2 subu no trap", 32'h7FFF_FFFF, 1'b0, 1'b1, 5'd5, 1'b0);
    apply(6'h00, 6'h23, 5'd0, 32'd0, 32'd1, 16'h0, 5'd6, 5'd1);
    expect_out("R2 subu wrap", 32'hFFFF_FFFF, 1'b0, 1'b1, 5'd6, 1'b0);
  endtask

  task automatic t_addi();
    apply(6'h08, 6'h3F, 5'd0, 32'd100, 32'hDEAD_BEEF, 16'hFFFF, 5'd2, 5'd7);
    expect_out("R3 addi negative imm", 32'd99, 1'b0, 1'b1, 5'd7, 1'b0);
    apply(6'h08, 6'h00, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd2, 5'd7);
    expect_out("R3 R9 addi overflow", 32'h8000_0000, 1'b1, 1'b0, 5'd7, 1'b0);
    apply(6'h09, 6'h00, 5'd0, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd2, 5'd7);
    expect_out("R3 addiu no trap", 32'h8000_0000, 1'b0, 1'b1, 5'd7, 1'b0);
    apply(6'h09, 6'h00, 5'd0, 32'd0, 32'h0, 16'h8000, 5'd2, 5'd8);
    expect_out("R3 addiu sign extend", 32'hFFFF_8000, 1'b0, 1'b1, 5'd8, 1'b0);
  endtask

  task automatic t_logic();
    apply(6'h0C, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001, 5'd2, 5'd10);
    expect_out("R4 andi zero pad", 32'h0000_8001, 1'b0, 1'b1, 5'd10, 1'b0);
    apply(6'h0D, 6'h00, 5'd0, 32'h1200_0000, 32'h0, 16'h8000, 5'd2, 5'd11);
    expect_out("R4 ori zero pad", 32'h1200_8000, 1'b0, 1'b1, 5'd11, 1'b0);
    apply(6'h00, 6'h24, 5'd0, 32'hF0F0_1234, 32'h0FF0_00FF, 16'h0, 5'd12, 5'd1);
    expect_out("R4 and", 32'h00F0_0034, 1'b0, 1'b1, 5'd12, 1'b0);
    apply(6'h00, 6'h25, 5'd0, 32'hF0F0_1234, 32'h0FF0_00FF, 16'h0, 5'd12, 5'd1);
    expect_out("R4 or", 32'hFFF0_12FF, 1'b0, 1'b1, 5'd12, 1'b0);
    apply(6'h00, 6'h26, 5'd0, 32'hF0F0_1234, 32'h0FF0_00FF, 16'h0, 5'd12, 5'd1);
    expect_out("R4 xor", 32'hFF00_12CB, 1'b0, 1'b1, 5'd12, 1'b0);
    apply(6'h00, 6'h27, 5'd0, 32'hF0F0_1234, 32'h0FF0_00FF, 16'h0, 5'd12, 5'd1);
    expect_out("R4 nor", 32'h000F_ED00, 1'b0, 1'b1, 5'd12, 1'b0);
  endtask

  task automatic t_compare();
    apply(6'h00, 6'h2A, 5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd13, 5'd1);
    expect_out("R5 slt -1<1", 32'd1, 1'b0, 1'b1, 5'd13, 1'b0);
    apply(6'h00, 6'h2A, 5'd0, 32'd1, 32'hFFFF_FFFF, 16'h0, 5'd13, 5'd1);
    expect_out("R5 slt 1<-1", 32'd0, 1'b0, 1'b1, 5'd13, 1'b0);
    apply(6'h00, 6'h2A, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd13, 5'd1);
    expect_out("R5 slt extremes", 32'd1, 1'b0, 1'b1, 5'd13, 1'b0);
    apply(6'h0A, 6'h00, 5'd0, 32'd5, 32'h0, 16'hFFFF, 5'd1, 5'd14);
    expect_out("R5 slti 5<-1", 32'd0, 1'b0, 1'b1, 5'd14, 1'b0);
    apply(6'h0A, 6'h00, 5'd0, 32'hFFFF_FFFB, 32'h0, 16'hFFFE, 5'd1, 5'd14);
    expect_out("R5 slti -5<-2", 32'd1, 1'b0, 1'b1, 5'd14, 1'b0);
  endtask

  task automatic t_shift();
    apply(6'h00, 6'h00, 5'd31, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd15, 5'd2);
    expect_out("R6 sll 31", 32'h8000_0000, 1'b0, 1'b1, 5'd15, 1'b0);
    apply(6'h00, 6'h02, 5'd4, 32'h0, 32'h8000_00F0, 16'h0, 5'd15, 5'd2);
    expect_out("R6 srl 4", 32'h0800_000F, 1'b0, 1'b1, 5'd15, 1'b0);
    apply(6'h00, 6'h03, 5'd4, 32'h0, 32'h8000_00F0, 16'h0, 5'd15, 5'd2);
    expect_out("R6 sra 4 negative", 32'hF800_000F, 1'b0, 1'b1, 5'd15, 1'b0);
    apply(6'h00, 6'h03, 5'd0, 32'h0, 32'h8123_4567, 16'h0, 5'd15, 5'd2);
    expect_out("R6 sra 0", 32'h8123_4567, 1'b0, 1'b1, 5'd15, 1'b0);
    apply(6'h00, 6'h03, 5'd8, 32'h0, 32'h7F00_0000, 16'h0, 5'd15, 5'd2);
    expect_out("R6 sra positive", 32'h007F_0000, 1'b0, 1'b1, 5'd15, 1'b0);
  endtask

  task automatic t_upper();
    apply(6'h0F, 6'h00, 5'd0, 32'h1234_5678, 32'h0, 16'hABCD, 5'd1, 5'd16);
    expect_out("R7 lui", 32'hABCD_0000, 1'b0, 1'b1, 5'd16, 1'b0);
  endtask

  task automatic t_zero_dest();
    apply(6'h00, 6'h21, 5'd0, 32'd2, 32'd3, 16'h0, 5'd0, 5'd9);
    expect_out("R8 rtype to r0", 32'd5, 1'b0, 1'b0, 5'd0, 1'b0);
    apply(6'h09, 6'h00, 5'd0, 32'd2, 32'd0, 16'h0003, 5'd9, 5'd0);
    expect_out("R8 itype to r0", 32'd5, 1'b0, 1'b0, 5'd0, 1'b0);
  endtask

  task automatic t_illegal();
    apply(6'h00, 6'h01, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd4, 5'd5);
    expect_out("R10 bad funct", 32'h0, 1'b0, 1'b0, 5'd4, 1'b1);
    apply(6'h3F, 6'h20, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0001, 5'd4, 5'd5);
    expect_out("R10 bad opcode", 32'h0, 1'b0, 1'b0, 5'd4, 1'b1);
    apply(6'h02, 6'h00, 5'd0, 32'd1, 32'd1, 16'h0001, 5'd6, 5'd5);
    expect_out("R10 jump opcode", 32'h0, 1'b0, 1'b0, 5'd6, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    op = '0; fn = '0; sa = '0; rs_val = '0; rt_val = '0; imm = '0; rd_idx = '0; rt_idx = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_addi();
    t_logic();
    t_compare();
    t_shift();
    t_upper();
    t_zero_dest();
    t_illegal();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule